// File: doc/BRIEF.md
# Trap Vector and Interrupt Arbitration Unit

This unit decides, one cycle at a time, whether the processor must leave its instruction stream. It does this for two kinds of event. The first is a synchronous exception presented by the core. The second is one of four asynchronous interrupt lines that the current priority level has not masked. When an event is taken, the unit turns it into a handler entry offset. It adds that offset to the handler base register to form the new program counter. It also forms the return address to save, which is the current PC with the privileged-mode flag folded into bit 0. It then asks the core to enter privileged mode.

The exception request uses a valid/ready handshake. The unit accepts `exc_valid_i` only in a cycle where `exc_ready_o` is high. `exc_ready_o` falls for exactly one cycle, the cycle in which a take is being reported. This gives the core one cycle to apply the new PC and mode before anything further is considered. While ready is low the requester must hold valid, cause and code stable. The request is accepted in the following cycle. Interrupt lines are plain level inputs and are sampled under the same one-cycle block. All results are registered, so they appear one cycle after the request is sampled, together with a one-cycle `take_o` pulse. The result outputs keep their last value between takes.

Top module: `trap_vector_unit`

## Requirements
- R1: During reset and right after it, `take_o` and `enter_priv_o` are 0, `new_pc_o`, `exc_addr_o`, `cause_o` and `code_o` are 0, and `exc_ready_o` is 1.
- R2: No interrupt is taken while `priv_i` is 1, whatever the lines and the level.
- R3: Interrupt line bits are device=bit 0, timer=bit 1, inter-processor=bit 2, machine-check=bit 3. Each level allows a different set of lines. Levels 0 to 3 allow all four lines. Level 4 allows all but device. Level 5 allows only inter-processor and machine-check. Level 6 allows only machine-check. Level 7 allows none.
- R4: Among the allowed pending lines, machine-check wins, then inter-processor, then timer, then device. The winner is reported on `cause_o` as 1, 2, 3 or 4 respectively.
- R5: Cause codes vector to fixed offsets equal to the cause times 0x80. The codes are reset=0, machine-check=1, inter-processor=2, timer=3, device=4, memory fault=5, unaligned=6, illegal opcode=7, arithmetic=8, floating point disabled=9.
- R6: For cause 10 (call trap), a call code with bit 7 set gives offset 0x2000 + (code-0x80)*64. Any other call code gives offset 0x1000 + code*64.
- R7: On a take, `new_pc_o` = `base_i` + offset and `exc_addr_o` = `pc_i` OR `priv_i` (bit 0). Both are taken from the request cycle. `enter_priv_o` pulses with `take_o`.
- R8: On a take, `code_o` carries the accepted call code for an exception and 0 for an interrupt.
- R9: An accepted exception takes precedence over any pending interrupt in the same cycle. An exception is taken even in privileged mode, and `cause_o` reports its cause.
- R10: The results appear one cycle after the request is sampled. `take_o` is never high in two consecutive cycles. `exc_ready_o` is 0 exactly while `take_o` is 1, and a request held across that cycle is taken again the cycle after.
- R11: Cause codes 11 to 15 are accepted, reported on `cause_o`, and use offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 4 | Interrupt request lines (device, timer, inter-processor, machine-check from bit 0) |
| ipl_i | input | 3 | Current interrupt priority level |
| priv_i | input | 1 | Processor is in privileged mode |
| pc_i | input | PC_W | Current program counter |
| base_i | input | PC_W | Handler base address |
| exc_valid_i | input | 1 | Synchronous exception request valid |
| exc_ready_o | output | 1 | Exception request can be accepted this cycle |
| exc_cause_i | input | 4 | Exception cause code |
| exc_code_i | input | 8 | Call code for call traps |
| take_o | output | 1 | One-cycle pulse: an event was taken |
| new_pc_o | output | PC_W | Handler entry address |
| exc_addr_o | output | PC_W | Saved return address with mode in bit 0 |
| enter_priv_o | output | 1 | Strobe to set privileged mode |
| cause_o | output | 4 | Cause of the taken event |
| code_o | output | 8 | Error code of the taken event |

## Verification
A wrong level threshold or priority order shows up as a wrong `cause_o` or a missing or extra `take_o`. This is visible one cycle after the offending line pattern. A fault in the offset arithmetic shows up in `new_pc_o` on that same pulse. If the one-cycle block state is stuck, `take_o` stays high for two cycles or `exc_ready_o` stays low, and either is visible in the cycle after the first take. The level, line and mode space is swept in full, and every cause code and every call code is applied.

// File: rtl/tvu_pkg.sv
package tvu_pkg;
  localparam int N_IRQ   = 4;
  localparam int LVL_W   = 3;
  localparam int CAUSE_W = 4;
  localparam int CODE_W  = 8;
  localparam int OFF_W   = 14;
  localparam int SLOT_SH = 6;   // call entries are 64 bytes apart
  localparam int FIX_SH  = 7;   // fixed entries are 128 bytes apart

  typedef enum logic [CAUSE_W-1:0] {
    CS_RESET   = 4'd0,
    CS_MCHK    = 4'd1,
    CS_IPI     = 4'd2,
    CS_TIMER   = 4'd3,
    CS_DEVICE  = 4'd4,
    CS_MEMFLT  = 4'd5,
    CS_UNALIGN = 4'd6,
    CS_ILLOP   = 4'd7,
    CS_ARITH   = 4'd8,
    CS_FPOFF   = 4'd9,
    CS_CALL    = 4'd10
  } cause_e;
endpackage

// File: rtl/tvu_irq_select.sv
module tvu_irq_select
  import tvu_pkg::*;
#(
  parameter int LINES    = N_IRQ,
  parameter int LW       = LVL_W,
  parameter int BASE_LVL = 3,
  localparam int IDX_W   = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_i,
  input  logic [LW-1:0]    lvl_i,
  input  logic             priv_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [LINES-1:0] allowed;

  // line k stays open up to level BASE_LVL + k
  for (genvar k = 0; k < LINES; k++) begin : g_mask
    localparam int LIMIT = BASE_LVL + k;
    assign allowed[k] = req_i[k] && (int'(lvl_i) <= LIMIT) && !priv_i;
  end

  // higher index means higher priority
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < LINES; k++) begin
      if (allowed[k]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/tvu_offset_map.sv
module tvu_offset_map
  import tvu_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic [OFF_W-1:0]   off_o
);
  localparam logic [OFF_W-1:0] CALL_LO_BASE = OFF_W'(14'h1000);
  localparam logic [OFF_W-1:0] CALL_HI_BASE = OFF_W'(14'h2000);

  logic [OFF_W-1:0] slot;
  logic [OFF_W-1:0] fixed;

  assign slot  = OFF_W'({code_i[CODE_W-2:0], {SLOT_SH{1'b0}}});
  assign fixed = OFF_W'({cause_i, {FIX_SH{1'b0}}});

  always_comb begin
    unique case (cause_i)
      CS_RESET, CS_MCHK, CS_IPI, CS_TIMER, CS_DEVICE,
      CS_MEMFLT, CS_UNALIGN, CS_ILLOP, CS_ARITH, CS_FPOFF:
        off_o = fixed;
      CS_CALL:
        off_o = (code_i[CODE_W-1] ? CALL_HI_BASE : CALL_LO_BASE) + slot;
      default:
        off_o = '0;
    endcase
  end
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import tvu_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic [LVL_W-1:0]   ipl_i,
  input  logic               priv_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    base_i,
  input  logic               exc_valid_i,
  output logic               exc_ready_o,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [CODE_W-1:0]  exc_code_i,
  output logic               take_o,
  output logic [PC_W-1:0]    new_pc_o,
  output logic [PC_W-1:0]    exc_addr_o,
  output logic               enter_priv_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [CODE_W-1:0]  code_o
);
  localparam int IDX_W = $clog2(N_IRQ);

  logic               take_q;
  logic               exc_fire;
  logic               irq_hit;
  logic [IDX_W-1:0]   irq_idx;
  logic               go;
  logic [CAUSE_W-1:0] sel_cause;
  logic [CODE_W-1:0]  sel_code;
  logic [OFF_W-1:0]   offset;

  assign exc_ready_o = !take_q;
  assign exc_fire    = exc_valid_i && exc_ready_o;

  tvu_irq_select #(
    .LINES   (N_IRQ),
    .LW      (LVL_W),
    .BASE_LVL(3)
  ) u_sel (
    .req_i (irq_i),
    .lvl_i (ipl_i),
    .priv_i(priv_i),
    .hit_o (irq_hit),
    .idx_o (irq_idx)
  );

  // exception first; interrupt lines map to causes N_IRQ - index
  always_comb begin
    if (exc_fire) begin
      sel_cause = exc_cause_i;
      sel_code  = exc_code_i;
    end else begin
      sel_cause = CAUSE_W'(N_IRQ) - CAUSE_W'(irq_idx);
      sel_code  = '0;
    end
  end

  assign go = exc_fire || (irq_hit && !take_q);

  tvu_offset_map u_map (
    .cause_i(sel_cause),
    .code_i (sel_code),
    .off_o  (offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q       <= 1'b0;
      enter_priv_o <= 1'b0;
      new_pc_o     <= '0;
      exc_addr_o   <= '0;
      cause_o      <= '0;
      code_o       <= '0;
    end else begin
      take_q       <= go;
      enter_priv_o <= go;
      if (go) begin
        new_pc_o   <= base_i + PC_W'(offset);
        exc_addr_o <= pc_i | PC_W'(priv_i);
        cause_o    <= sel_cause;
        code_o     <= sel_code;
      end
    end
  end

  assign take_o = take_q;
endmodule

// File: rtl/tvu_checker.sv
module tvu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ipl_i,
  input logic       priv_i,
  input logic       exc_valid_i,
  input logic       exc_ready_o,
  input logic [3:0] exc_cause_i,
  input logic       take_o,
  input logic       enter_priv_o,
  input logic       addr_lsb,
  input logic [3:0] cause_o,
  input logic [7:0] code_o
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R10

  AST_PRIV_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(exc_valid_i && exc_ready_o)) |-> !$past(priv_i)); // R2

  AST_LEVEL_SEVEN_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(exc_valid_i && exc_ready_o)) |-> ($past(ipl_i) != 3'd7)); // R3

  AST_IRQ_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(exc_valid_i && exc_ready_o)) |-> (code_o == 8'd0)); // R8

  AST_EXC_PRECEDENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && exc_ready_o) |=> (take_o && cause_o == $past(exc_cause_i))); // R9

  AST_MODE_BIT_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (addr_lsb == $past(priv_i) && enter_priv_o)); // R7
endmodule

bind trap_vector_unit tvu_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ipl_i       (ipl_i),
  .priv_i      (priv_i),
  .exc_valid_i (exc_valid_i),
  .exc_ready_o (exc_ready_o),
  .exc_cause_i (exc_cause_i),
  .take_o      (take_o),
  .enter_priv_o(enter_priv_o),
  .addr_lsb    (exc_addr_o[0]),
  .cause_o     (cause_o),
  .code_o      (code_o)
);

// File: tb/trap_vector_unit_tb.sv
module trap_vector_unit_tb;
  localparam int PC_W = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      irq_i = '0;
  logic [2:0]      ipl_i = '0;
  logic            priv_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic [PC_W-1:0] base_i = '0;
  logic            exc_valid_i = 1'b0;
  logic            exc_ready_o;
  logic [3:0]      exc_cause_i = '0;
  logic [7:0]      exc_code_i = '0;
  logic            take_o;
  logic [PC_W-1:0] new_pc_o;
  logic [PC_W-1:0] exc_addr_o;
  logic            enter_priv_o;
  logic [3:0]      cause_o;
  logic [7:0]      code_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = !clk;

  trap_vector_unit #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ipl_i(ipl_i), .priv_i(priv_i),
    .pc_i(pc_i), .base_i(base_i), .exc_valid_i(exc_valid_i),
    .exc_ready_o(exc_ready_o), .exc_cause_i(exc_cause_i),
    .exc_code_i(exc_code_i), .take_o(take_o), .new_pc_o(new_pc_o),
    .exc_addr_o(exc_addr_o), .enter_priv_o(enter_priv_o),
    .cause_o(cause_o), .code_o(code_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected interrupt cause from the level rules, 0 when nothing is taken
  function automatic int exp_irq(input logic [3:0] lines, input int lvl, input bit priv);
    if (priv) return 0;
    for (int k = 3; k >= 0; k--)
      if (lines[k] && lvl <= 3 + k) return 4 - k;
    return 0;
  endfunction

  function automatic logic [63:0] exp_off(input int cause, input int code);
    if (cause == 10) return (code >= 128) ? 64'(32'h2000 + (code - 128) * 64)
                                          : 64'(32'h1000 + code * 64);
    if (cause <= 9) return 64'(cause * 128);
    return 64'd0;
  endfunction

  task automatic idle();
    irq_i = '0; exc_valid_i = 1'b0;
  endtask

  task automatic run_one(input logic [3:0] lines, input int lvl, input bit priv,
                         input bit ev, input int cause, input int code,
                         input logic [63:0] pc, input logic [63:0] base,
                         input string tag);
    int ec; int ecode; bit et;
    @(negedge clk);
    irq_i = lines; ipl_i = 3'(lvl); priv_i = priv; exc_valid_i = ev;
    exc_cause_i = 4'(cause); exc_code_i = 8'(code); pc_i = pc; base_i = base;
    if (ev) begin et = 1; ec = cause; ecode = code; end
    else begin ec = exp_irq(lines, lvl, priv); et = (ec != 0); ecode = 0; end
    @(negedge clk);
    idle();
    check({tag, " take"}, 64'(take_o), 64'(et));
    if (et) begin
      check({tag, " R7 new_pc"}, new_pc_o, base + exp_off(ec, ecode));
      check({tag, " R7 exc_addr"}, exc_addr_o, pc | 64'(priv));
      check({tag, " R7 enter_priv"}, 64'(enter_priv_o), 64'd1);
      check({tag, " cause"}, 64'(cause_o), 64'(ec));
      check({tag, " R8 code"}, 64'(code_o), 64'(ecode));
      check({tag, " R10 ready low"}, 64'(exc_ready_o), 64'd0);
    end
    @(negedge clk);
    check({tag, " R10 pulse ends"}, 64'(take_o), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset take", 64'(take_o), 64'd0);
    check("R1 reset ready", 64'(exc_ready_o), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post take", 64'(take_o), 64'd0);
    check("R1 post new_pc", new_pc_o, 64'd0);
    check("R1 post exc_addr", exc_addr_o, 64'd0);
    check("R1 post cause/code", 64'({cause_o, code_o, enter_priv_o}), 64'd0);

    // R2 R3 R4: full sweep of level, lines and mode
    for (int lvl = 0; lvl < 8; lvl++)
      for (int ln = 0; ln < 16; ln++)
        for (int p = 0; p < 2; p++)
          run_one(4'(ln), lvl, p[0], 1'b0, 0, 0,
                  64'hFFFF_0000_0012_3400 + 64'(ln * 16),
                  64'h0000_0001_8000_0000 + 64'(lvl * 32'h10000),
                  "R2 R3 R4 irq");

    // R5 R11: every cause code
    for (int c = 0; c < 16; c++)
      run_one(4'h0, 0, c[0], 1'b1, c, 8'h35, 64'h0000_0000_2000_0040 + 64'(c * 8),
              64'h0000_0000_0010_0000, (c > 10) ? "R11 cause" : "R5 cause");

    // R6: every call code
    for (int k = 0; k < 256; k++)
      run_one(4'h0, 7, 1'b0, 1'b1, 10, k, 64'h1234_5678_0000_1000,
              64'h0000_7FFF_FFFF_0000, "R6 call");

    // R9: exception wins over all lines at level 0, also in privileged mode
    for (int c = 5; c < 11; c++) begin
      run_one(4'hF, 0, 1'b0, 1'b1, c, 8'h81, 64'h40, 64'h8000, "R9 vs irq");
      run_one(4'hF, 0, 1'b1, 1'b1, c, 8'h02, 64'h80, 64'h8000, "R9 priv");
    end

    // R10: request held across the blocked cycle
    @(negedge clk);
    priv_i = 1'b0; ipl_i = 3'd7; irq_i = 4'h0;
    exc_valid_i = 1'b1; exc_cause_i = 4'd8; exc_code_i = 8'h00;
    pc_i = 64'h100; base_i = 64'h4000;
    @(negedge clk);
    check("R10 first take", 64'(take_o), 64'd1);
    check("R10 ready during take", 64'(exc_ready_o), 64'd0);
    @(negedge clk);
    check("R10 blocked cycle", 64'(take_o), 64'd0);
    check("R10 ready back", 64'(exc_ready_o), 64'd1);
    @(negedge clk);
    check("R10 retaken", 64'(take_o), 64'd1);
    check("R10 retaken pc", new_pc_o, 64'h4400);
    idle();
    // held interrupt alternates
    @(negedge clk);
    irq_i = 4'h2; ipl_i = 3'd4;
    @(negedge clk);
    check("R10 irq take", 64'(take_o), 64'd1);
    check("R4 irq cause timer", 64'(cause_o), 64'd3);
    @(negedge clk);
    check("R10 irq blocked", 64'(take_o), 64'd0);
    @(negedge clk);
    check("R10 irq retaken", 64'(take_o), 64'd1);
    idle();
    @(negedge clk);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule